// File: doc/BRIEF.md
# Converter-Side Serial Sample Shifter

This block models the digital output side of a 14-bit serial converter. A host lowers an active-low select line and then supplies a serial clock. The block latches the parallel sample on the falling edge of select. It presents one serial frame made of two leading zeros followed by the sample, most significant bit first. The serial line has its own output-enable signal. A hold flag follows the converter's track/hold state.

The first leading zero is on the line as soon as select falls, with no clock edge needed. Each later bit is launched on a serial-clock falling edge. Each bit stays valid through the rising edge that follows, so a receiver may sample on either edge. The hold flag returns low on the rising edge after the fifteenth falling edge. The enable drops on the sixteenth falling edge. Raising select at any time ends the frame at once and resets the bit counter. The serial output is held at 0 whenever the enable is low, so the line never needs a high-impedance model.

Top module: `serial_sample_shifter`

## Requirements
- R1: When select_n falls, with no serial clock edge, sdata_oe and hold both go to 1 and sdata is 0 (the first leading zero).
- R2: The sample value present when select_n falls is the one shifted out. Changes to sample during the frame have no effect on sdata.
- R3: Falling edge 1 of the frame drives a 0 (the second leading zero). Falling edge k, for k from 2 to 15, drives sample bit 15-k: bit 13 on edge 2 and bit 0 on edge 15.
- R4: Each launched bit stays unchanged on sdata through the rising edge after the falling edge that launched it.
- R5: On falling edge 16, sdata_oe goes to 0 and sdata goes to 0.
- R6: hold stays 1 until the rising edge that follows falling edge 15, and is 0 from that edge to the end of the frame.
- R7: If select_n rises before falling edge 16, sdata_oe, sdata and hold all go to 0 at once, with no clock edge needed.
- R8: Further serial clock edges after falling edge 16, while select_n stays low, leave sdata_oe, sdata and hold at 0.
- R9: While select_n is high, all outputs are 0 and the bit counter is held cleared, so every frame starts again from the first leading zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| select_n | input | 1 | Active-low frame select. Falling edge latches the sample and starts the frame; high aborts the frame or keeps the block idle |
| sclk | input | 1 | Serial clock from the host. Falling edges launch bits; rising edges update the hold flag |
| sample | input | 14 | Parallel sample value, latched on the falling edge of select_n |
| sdata | output | 1 | Serial data bit, forced to 0 while sdata_oe is low |
| sdata_oe | output | 1 | Output enable for the serial data line |
| hold | output | 1 | 1 while the converter is in hold, 0 while it is tracking |

## Verification
The assertions are clocked on serial-clock edges and are turned off while select_n is high. They therefore assume that select_n never changes at the same instant as a serial-clock edge, and that sclk is idle high whenever select_n toggles. The bench keeps to both rules. It raises sclk before every select change, and it waits a quarter period or more between any select change and the next clock edge. The assertions also assume the sample input is stable when select_n falls. The bench sets sample well before lowering select and changes it only later in the frame.

// File: rtl/ssh_pkg.sv
package ssh_pkg;

    localparam int unsigned SSH_DATA_W_DEF = 14;
    localparam int unsigned SSH_LEAD_DEF   = 2;

    function automatic int unsigned ssh_frame_len(input int unsigned data_w,
                                                  input int unsigned lead);
        return data_w + lead;
    endfunction

endpackage

// File: rtl/ssh_bit_counter.sv
module ssh_bit_counter #(
    parameter int unsigned FRAME = 16,
    parameter int unsigned CNT_W = 5
) (
    input  logic             sclk,
    input  logic             select_n,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != CNT_W'(FRAME)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(negedge sclk or posedge select_n) begin
        if (select_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R8
    cnt_bound_chk: assert property (@(negedge sclk) disable iff (select_n)
        st_q.cnt <= CNT_W'(FRAME));

endmodule

// File: rtl/ssh_hold_track.sv
module ssh_hold_track #(
    parameter int unsigned FRAME = 16,
    parameter int unsigned CNT_W = 5
) (
    input  logic             sclk,
    input  logic             select_n,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             hold_o
);

    localparam logic [CNT_W-1:0] REL_CNT = CNT_W'(FRAME - 1);

    typedef struct packed {
        logic released;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cnt_i >= REL_CNT) begin
            st_d.released = 1'b1;
        end
    end

    always_ff @(posedge sclk or posedge select_n) begin
        if (select_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = !select_n && !st_q.released;

    // R6
    hold_early_chk: assert property (@(negedge sclk) disable iff (select_n)
        (cnt_i < REL_CNT) |-> hold_o);

    // R6
    track_late_chk: assert property (@(posedge sclk) disable iff (select_n)
        !hold_o |-> (cnt_i >= REL_CNT));

endmodule

// File: rtl/ssh_data_mux.sv
module ssh_data_mux #(
    parameter int unsigned DATA_W = 14,
    parameter int unsigned LEAD   = 2,
    parameter int unsigned FRAME  = 16,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              sclk,
    input  logic              select_n,
    input  logic [DATA_W-1:0] sample,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              sdata_o,
    output logic              oe_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } cap_state_t;

    cap_state_t cap_d, cap_q;
    logic       bit_sel;

    always_comb begin
        cap_d.word = sample;
    end

    always_ff @(negedge select_n) begin
        cap_q <= cap_d;
    end

    always_comb begin
        bit_sel = 1'b0;
        for (int b = 0; b < int'(DATA_W); b++) begin
            if (cnt_i == CNT_W'(int'(LEAD) + int'(DATA_W) - 1 - b)) begin
                bit_sel = cap_q.word[b];
            end
        end
    end

    assign oe_o    = !select_n && (cnt_i < CNT_W'(FRAME));
    assign sdata_o = oe_o && bit_sel;

    // R3
    lead_zero_chk: assert property (@(posedge sclk) disable iff (select_n)
        (cnt_i < CNT_W'(LEAD)) |-> !sdata_o);

endmodule

// File: rtl/serial_sample_shifter.sv
module serial_sample_shifter
    import ssh_pkg::*;
#(
    parameter int unsigned DATA_W = SSH_DATA_W_DEF,
    parameter int unsigned LEAD   = SSH_LEAD_DEF
) (
    input  logic              select_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              hold
);

    localparam int unsigned FRAME = ssh_frame_len(DATA_W, LEAD);
    localparam int unsigned CNT_W = $clog2(FRAME + 1);

    logic [CNT_W-1:0] bit_cnt;

    ssh_bit_counter #(
        .FRAME (FRAME),
        .CNT_W (CNT_W)
    ) cnt_i (
        .sclk     (sclk),
        .select_n (select_n),
        .cnt_o    (bit_cnt)
    );

    ssh_hold_track #(
        .FRAME (FRAME),
        .CNT_W (CNT_W)
    ) hold_i (
        .sclk     (sclk),
        .select_n (select_n),
        .cnt_i    (bit_cnt),
        .hold_o   (hold)
    );

    ssh_data_mux #(
        .DATA_W (DATA_W),
        .LEAD   (LEAD),
        .FRAME  (FRAME),
        .CNT_W  (CNT_W)
    ) mux_i (
        .sclk     (sclk),
        .select_n (select_n),
        .sample   (sample),
        .cnt_i    (bit_cnt),
        .sdata_o  (sdata),
        .oe_o     (sdata_oe)
    );

    // R5
    oe_after_hold_chk: assert property (@(posedge sclk) disable iff (select_n)
        !sdata_oe |-> !hold);

endmodule

// File: tb/serial_sample_shifter_tb_top.sv
module serial_sample_shifter_tb_top;

    localparam int SCLK_PERIOD = 20;
    localparam int Q = SCLK_PERIOD / 4;

    typedef struct packed {
        logic [13:0] smp;
        logic [5:0]  edges;
        logic        chg;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{14'h3FFF, 6'd16, 1'b0},
        '{14'h0000, 6'd16, 1'b0},
        '{14'h2AAA, 6'd16, 1'b1},
        '{14'h1555, 6'd20, 1'b0},
        '{14'h2C35, 6'd9,  1'b0},
        '{14'h3A5C, 6'd15, 1'b1},
        '{14'h0001, 6'd1,  1'b0}
    };

    logic        select_n;
    logic        sclk;
    logic [13:0] sample;
    logic        sdata;
    logic        sdata_oe;
    logic        hold;

    int checks = 0;
    int fails  = 0;

    serial_sample_shifter dut_i (
        .select_n (select_n),
        .sclk     (sclk),
        .sample   (sample),
        .sdata    (sdata),
        .sdata_oe (sdata_oe),
        .hold     (hold)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [13:0] smp, input int k);
        if (k < 2 || k > 15) return 1'b0;
        return smp[15 - k];
    endfunction

    task automatic run_frame(input logic [13:0] smp, input int edges, input logic chg);
        sample = smp;
        #(Q);
        select_n = 1'b0;
        #(Q);
        // R1
        chk("R1 oe", sdata_oe, 1'b1);
        chk("R1 hold", hold, 1'b1);
        chk("R1 sdata", sdata, 1'b0);
        // R2: input change after capture must not matter
        if (chg) sample = ~smp;
        for (int k = 1; k <= edges; k++) begin
            #(Q);
            sclk = 1'b0;
            #(Q);
            if (k <= 15) begin
                chk("R3 sdata", sdata, exp_bit(smp, k));
                chk("R3 oe", sdata_oe, 1'b1);
                if (chg) chk("R2 sdata", sdata, exp_bit(smp, k));
            end else if (k == 16) begin
                chk("R5 oe", sdata_oe, 1'b0);
                chk("R5 sdata", sdata, 1'b0);
            end else begin
                chk("R8 oe", sdata_oe, 1'b0);
                chk("R8 sdata", sdata, 1'b0);
                chk("R8 hold", hold, 1'b0);
            end
            #(Q);
            sclk = 1'b1;
            #(Q);
            if (k <= 15) chk("R4 sdata", sdata, exp_bit(smp, k));
            chk("R6 hold", hold, (k < 15) ? 1'b1 : 1'b0);
        end
        #(Q);
        select_n = 1'b1;
        #(Q);
        if (edges < 16) begin
            chk("R7 oe", sdata_oe, 1'b0);
            chk("R7 sdata", sdata, 1'b0);
            chk("R7 hold", hold, 1'b0);
        end else begin
            chk("R9 oe", sdata_oe, 1'b0);
            chk("R9 hold", hold, 1'b0);
        end
        #(SCLK_PERIOD);
    endtask

    initial begin
        #(SCLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        sclk     = 1'b1;
        select_n = 1'b0;
        sample   = '0;
        #2;
        select_n = 1'b1;
        #(SCLK_PERIOD);
        // R9 idle state
        chk("R9 reset oe", sdata_oe, 1'b0);
        chk("R9 reset sdata", sdata, 1'b0);
        chk("R9 reset hold", hold, 1'b0);
        // R9: clock edges while idle have no effect
        for (int k = 0; k < 3; k++) begin
            #(Q) sclk = 1'b0;
            #(Q) chk("R9 idle oe", sdata_oe, 1'b0);
            #(Q) sclk = 1'b1;
            #(Q) chk("R9 idle hold", hold, 1'b0);
        end

        for (int v = 0; v < NV; v++) begin
            run_frame(VECS[v].smp, int'(VECS[v].edges), VECS[v].chg);
        end

        // R9: aborted frame followed by a full frame restarts from the first zero
        run_frame(14'h2001, 4, 1'b0);
        run_frame(14'h3FFE, 16, 1'b0);
        // R7: abort just after the first select fall, no clock at all
        run_frame(14'h3FFF, 0, 1'b0);
        // R8: long overrun
        run_frame(14'h0F0F, 24, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule